// File: doc/BRIEF.md
# NaN Precision Conversion Unit

This combinational unit takes a NaN held in one floating-point precision and re-expresses it in another: single (32-bit), double (64-bit) or 80-bit extended. Every source is first reduced to an internal canonical form, a sign bit plus a 64-bit payload with the most significant fraction bit at payload bit 63. The destination word is then rebuilt from that canonical form. Because the payload is left-justified, the high-order fraction bits survive a change of precision, and narrowing drops only low-order bits.

The extended format is carried on two buses. A 16-bit upper field holds the sign in bit 15 and the exponent in bits 14:0. A 64-bit significand holds an explicit integer bit in bit 63. Single and double values travel right-aligned on the 64-bit bus. The unit also reports whether the source was a signaling NaN. It never sets the quiet bit of its result, so any quieting belongs to the caller. The unit is only defined for NaN inputs; ordinary numbers, rounding and denormals are outside its job.

Top module: `nan_fmt_xlate`

## Requirements
- R1: The result sign equals the source's top bit: bit 31 of a single source, bit 63 of a double source, or bit 15 of the extended upper field. This holds except where a fixed default NaN replaces the result.
- R2: A single source's 23 fraction bits land in payload bits 63:41. Converted to double, a single NaN with fraction f becomes {sign, 0x7FF, f, 29 zero bits}.
- R3: A double source's 52 fraction bits land in payload bits 63:12. Converted to single, the result keeps double fraction bits 51:29 as its 23-bit fraction.
- R4: An extended source's full 64-bit significand, integer bit included, becomes the payload unchanged. An extended result takes the payload as its significand and {sign, 0x7FFF} as its upper field.
- R5: The invalid output is 1 exactly when the source is a signaling NaN under its own format's rule. For single: exponent 0xFF, bit 22 clear, bits 21:0 non-zero. For double: exponent 0x7FF, bit 51 clear, bits 50:0 non-zero. For extended: exponent 0x7FFF, significand bit 62 clear, bits 61:0 non-zero.
- R6: The quiet bit of the result (single bit 22, double bit 51, extended significand bit 62) is copied from the payload and is never forced to 1.
- R7: If the fraction kept for a single result is zero, the result is 0xFFC00000. If the fraction kept for a double result is zero, the result is 0xFFF8000000000000. A zero payload gives an extended significand of 0xC000000000000000.
- R8: Format codes are 0 for single, 1 for double and 2 for extended. A single result sits in res_lo[31:0], with res_lo[63:32] and res_hi zero. A double result fills res_lo, with res_hi zero.
- R9: Source code 3 gives the destination's default NaN with invalid 0; for an extended destination this is upper field 0x7FFF and significand 0xC000000000000000. Destination code 3 drives res_hi and res_lo to zero while invalid still follows the source.
- R10: A single NaN converted to double and that double converted back to single reproduces the original 32-bit word.
- R11: The unit holds no state. Its outputs reflect the current inputs within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_hi | input | 16 | Extended source sign and exponent field (ignored otherwise) |
| src_lo | input | 64 | Source word: single in [31:0], double in full, or extended significand |
| src_fmt | input | 2 | Source format code |
| dst_fmt | input | 2 | Destination format code |
| res_hi | output | 16 | Extended result sign and exponent field, zero for other formats |
| res_lo | output | 64 | Result word or extended significand |
| invalid | output | 1 | Source was a signaling NaN |

## Verification
The bench checks truncation when narrowing. Double payloads that live only in fraction bits 28:0 must collapse to the single default. A unit that kept the low bits, or sliced the wrong end of the payload, would return a NaN carrying garbage. Round trips from single to double and back check that the left-justification is consistent. A misaligned shift in either direction breaks those round trips. Signaling sources of each format are checked for the invalid flag and for a quiet bit that stays clear, which catches a unit that quiets its output. An extended significand holding only the integer bit must not be flagged, and an all-zero significand must yield the extended default. Reserved codes on each side are also covered.

// File: rtl/nan_fmt_pkg.sv
package nan_fmt_pkg;

    localparam int PAY_W      = 64;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int SGL_W      = 1 + SGL_EXP_W + SGL_FRAC_W;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int DBL_W      = 1 + DBL_EXP_W + DBL_FRAC_W;
    localparam int EXT_EXP_W  = 15;
    localparam int EXT_HI_W   = 1 + EXT_EXP_W;
    localparam int SGL_PAD    = PAY_W - SGL_FRAC_W;
    localparam int DBL_PAD    = PAY_W - DBL_FRAC_W;

    typedef enum logic [1:0] {
        FMT_SGL = 2'd0,
        FMT_DBL = 2'd1,
        FMT_EXT = 2'd2,
        FMT_RSV = 2'd3
    } nan_fmt_e;

    typedef struct packed {
        logic             sign;
        logic [PAY_W-1:0] payload;
    } canon_t;

    localparam logic [SGL_W-1:0] SGL_DFLT     = 32'hFFC0_0000;
    localparam logic [DBL_W-1:0] DBL_DFLT     = 64'hFFF8_0000_0000_0000;
    localparam logic [PAY_W-1:0] EXT_DFLT_SIG = 64'hC000_0000_0000_0000;

    // body excludes the sign bit
    function automatic logic snan_sgl(input logic [SGL_W-2:0] body);
        return (&body[SGL_W-2:SGL_FRAC_W]) && !body[SGL_FRAC_W-1]
               && (|body[SGL_FRAC_W-2:0]);
    endfunction

    function automatic logic snan_dbl(input logic [DBL_W-2:0] body);
        return (&body[DBL_W-2:DBL_FRAC_W]) && !body[DBL_FRAC_W-1]
               && (|body[DBL_FRAC_W-2:0]);
    endfunction

    function automatic logic snan_ext(input logic [EXT_EXP_W-1:0] expo,
                                      input logic [PAY_W-2:0]     sig);
        return (&expo) && !sig[PAY_W-2] && (|sig[PAY_W-3:0]);
    endfunction

endpackage

// File: rtl/nan_unpack.sv
module nan_unpack
    import nan_fmt_pkg::*;
(
    input  logic [EXT_HI_W-1:0] src_hi,
    input  logic [PAY_W-1:0]    src_lo,
    input  nan_fmt_e            src_fmt,
    output canon_t              canon,
    output logic                is_snan
);

    always_comb begin
        canon   = '0;
        is_snan = 1'b0;
        case (src_fmt)
            FMT_SGL: begin
                canon.sign    = src_lo[SGL_W-1];
                canon.payload = {src_lo[SGL_FRAC_W-1:0], {SGL_PAD{1'b0}}};
                is_snan       = snan_sgl(src_lo[SGL_W-2:0]);
            end
            FMT_DBL: begin
                canon.sign    = src_lo[DBL_W-1];
                canon.payload = {src_lo[DBL_FRAC_W-1:0], {DBL_PAD{1'b0}}};
                is_snan       = snan_dbl(src_lo[DBL_W-2:0]);
            end
            FMT_EXT: begin
                canon.sign    = src_hi[EXT_HI_W-1];
                canon.payload = src_lo;
                is_snan       = snan_ext(src_hi[EXT_EXP_W-1:0], src_lo[PAY_W-2:0]);
            end
            default: begin
                canon   = '0;
                is_snan = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/nan_pack.sv
module nan_pack
    import nan_fmt_pkg::*;
(
    input  canon_t              canon,
    input  nan_fmt_e            dst_fmt,
    output logic [EXT_HI_W-1:0] res_hi,
    output logic [PAY_W-1:0]    res_lo
);

    logic [SGL_FRAC_W-1:0] sgl_frac;
    logic [DBL_FRAC_W-1:0] dbl_frac;
    logic [SGL_W-1:0]      sgl_word;
    logic [DBL_W-1:0]      dbl_word;
    logic [PAY_W-1:0]      ext_sig;

    assign sgl_frac = canon.payload[PAY_W-1 -: SGL_FRAC_W];
    assign dbl_frac = canon.payload[PAY_W-1 -: DBL_FRAC_W];

    assign sgl_word = (sgl_frac == '0) ? SGL_DFLT
                    : {canon.sign, {SGL_EXP_W{1'b1}}, sgl_frac};
    assign dbl_word = (dbl_frac == '0) ? DBL_DFLT
                    : {canon.sign, {DBL_EXP_W{1'b1}}, dbl_frac};
    assign ext_sig  = (canon.payload == '0) ? EXT_DFLT_SIG : canon.payload;

    always_comb begin
        res_hi = '0;
        res_lo = '0;
        case (dst_fmt)
            FMT_SGL: res_lo = {{(PAY_W-SGL_W){1'b0}}, sgl_word};
            FMT_DBL: res_lo = dbl_word;
            FMT_EXT: begin
                res_hi = {canon.sign, {EXT_EXP_W{1'b1}}};
                res_lo = ext_sig;
            end
            default: begin
                res_hi = '0;
                res_lo = '0;
            end
        endcase
    end

endmodule

// File: rtl/nan_fmt_xlate.sv
module nan_fmt_xlate
    import nan_fmt_pkg::*;
(
    input  logic [15:0] src_hi,
    input  logic [63:0] src_lo,
    input  logic [1:0]  src_fmt,
    input  logic [1:0]  dst_fmt,
    output logic [15:0] res_hi,
    output logic [63:0] res_lo,
    output logic        invalid
);

    canon_t canon;

    nan_unpack u_unpack (
        .src_hi  (src_hi),
        .src_lo  (src_lo),
        .src_fmt (nan_fmt_e'(src_fmt)),
        .canon   (canon),
        .is_snan (invalid)
    );

    nan_pack u_pack (
        .canon   (canon),
        .dst_fmt (nan_fmt_e'(dst_fmt)),
        .res_hi  (res_hi),
        .res_lo  (res_lo)
    );

endmodule

// File: rtl/nan_fmt_xlate_chk.sv
module nan_fmt_xlate_chk (
    input logic [15:0] src_hi,
    input logic [63:0] src_lo,
    input logic [1:0]  src_fmt,
    input logic [1:0]  dst_fmt,
    input logic [15:0] res_hi,
    input logic [63:0] res_lo,
    input logic        invalid
);

    logic src_exp_ones, src_frac_nz, src_sign;
    logic res_exp_ones, res_frac_nz, res_quiet, pad_zero;

    always_comb begin
        case (src_fmt)
            2'd0: begin
                src_exp_ones = &src_lo[30:23];
                src_frac_nz  = |src_lo[22:0];
                src_sign     = src_lo[31];
            end
            2'd1: begin
                src_exp_ones = &src_lo[62:52];
                src_frac_nz  = |src_lo[51:0];
                src_sign     = src_lo[63];
            end
            2'd2: begin
                src_exp_ones = &src_hi[14:0];
                src_frac_nz  = |src_lo;
                src_sign     = src_hi[15];
            end
            default: begin
                src_exp_ones = 1'b0;
                src_frac_nz  = 1'b0;
                src_sign     = 1'b0;
            end
        endcase
        case (dst_fmt)
            2'd0: begin
                res_exp_ones = &res_lo[30:23];
                res_frac_nz  = |res_lo[22:0];
                res_quiet    = res_lo[22];
                pad_zero     = (res_hi == 16'h0) && (res_lo[63:32] == 32'h0);
            end
            2'd1: begin
                res_exp_ones = &res_lo[62:52];
                res_frac_nz  = |res_lo[51:0];
                res_quiet    = res_lo[51];
                pad_zero     = (res_hi == 16'h0);
            end
            2'd2: begin
                res_exp_ones = &res_hi[14:0];
                res_frac_nz  = |res_lo;
                res_quiet    = res_lo[62];
                pad_zero     = 1'b1;
            end
            default: begin
                res_exp_ones = 1'b0;
                res_frac_nz  = 1'b0;
                res_quiet    = 1'b0;
                pad_zero     = 1'b1;
            end
        endcase
    end

    always_comb begin
        if (dst_fmt != 2'd3) begin
            assert_nan_shape_R8: assert (res_exp_ones && res_frac_nz && pad_zero)
                else $error("result is not a NaN in the destination format");
        end
        if (dst_fmt == 2'd3) begin
            assert_reserved_dst_R9: assert (res_hi == 16'h0 && res_lo == 64'h0)
                else $error("reserved destination did not give zero");
        end
        if (invalid) begin
            assert_flag_source_R5: assert (src_exp_ones && src_frac_nz)
                else $error("invalid raised for a source that is not a NaN");
        end
        if (src_fmt == dst_fmt && src_fmt != 2'd3 && src_exp_ones && src_frac_nz) begin
            assert_same_fmt_identity_R4: assert (res_lo == src_lo
                    && (src_fmt != 2'd2 || res_hi == src_hi))
                else $error("same-format conversion altered the NaN");
        end
        if (invalid && src_fmt == dst_fmt) begin
            assert_no_quieting_R6: assert (!res_quiet)
                else $error("signaling source came out quieted");
        end
        if (dst_fmt == 2'd2 && src_fmt != 2'd3) begin
            assert_sign_kept_R1: assert (res_hi[15] == src_sign)
                else $error("extended result lost the source sign");
        end
    end

endmodule

bind nan_fmt_xlate nan_fmt_xlate_chk u_chk (
    .src_hi  (src_hi),
    .src_lo  (src_lo),
    .src_fmt (src_fmt),
    .dst_fmt (dst_fmt),
    .res_hi  (res_hi),
    .res_lo  (res_lo),
    .invalid (invalid)
);

// File: tb/test_nan_fmt_xlate.sv
module test_nan_fmt_xlate;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_hi = '0;
    logic [63:0] src_lo = '0;
    logic [1:0]  src_fmt = '0;
    logic [1:0]  dst_fmt = '0;
    logic [15:0] res_hi;
    logic [63:0] res_lo;
    logic        invalid;

    typedef struct {
        logic [15:0] hi;
        logic [63:0] lo;
        logic        inv;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nan_fmt_xlate i_nan_fmt_xlate (
        .src_hi  (src_hi),
        .src_lo  (src_lo),
        .src_fmt (src_fmt),
        .dst_fmt (dst_fmt),
        .res_hi  (res_hi),
        .res_lo  (res_lo),
        .invalid (invalid)
    );

    // Driven just after a rising edge, checked at the falling edge of the same cycle (R11)
    task automatic send(input logic [15:0] sh, input logic [63:0] sl,
                        input logic [1:0] sf, input logic [1:0] df,
                        input logic [15:0] eh, input logic [63:0] el,
                        input logic ei, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        src_hi  = sh;
        src_lo  = sl;
        src_fmt = sf;
        dst_fmt = df;
        e.hi = eh; e.lo = el; e.inv = ei; e.tag = tag;
        sb_q.push_back(e);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (res_hi !== e.hi || res_lo !== e.lo || invalid !== e.inv) begin
                    n_bad++;
                    $display("FAIL %s: got hi=%h lo=%h inv=%b, expected hi=%h lo=%h inv=%b",
                             e.tag, res_hi, res_lo, invalid, e.hi, e.lo, e.inv);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (R11): got no completion, expected finish within %0d cycles",
                     WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle inputs: zero single source gives the single default (R7, R11)
        send(16'h0, 64'h0, 2'd0, 2'd0, 16'h0, 64'hFFC0_0000, 1'b0, "R7 idle zero sgl->sgl");
        send(16'h0, 64'h7FC1_2345, 2'd0, 2'd0, 16'h0, 64'h7FC1_2345, 1'b0, "R8 quiet sgl->sgl");
        send(16'h0, 64'h7F81_2345, 2'd0, 2'd0, 16'h0, 64'h7F81_2345, 1'b1, "R5 R6 signaling sgl kept");
        send(16'h0, 64'hFF80_0001, 2'd0, 2'd1, 16'h0, 64'hFFF0_0000_2000_0000, 1'b1,
             "R1 R2 negative sgl->dbl");
        send(16'h0, 64'h7FF8_0000_0000_0001, 2'd1, 2'd0, 16'h0, 64'h7FC0_0000, 1'b0,
             "R3 dbl->sgl truncation");
        send(16'h0, 64'h7FF0_0000_1FFF_FFFF, 2'd1, 2'd0, 16'h0, 64'hFFC0_0000, 1'b1,
             "R3 R7 dbl low bits collapse");
        send(16'h0, 64'h7FF4_0000_0000_0000, 2'd1, 2'd2, 16'h7FFF, 64'h4000_0000_0000_0000, 1'b1,
             "R4 R6 dbl->ext unquieted");
        send(16'hFFFF, 64'hC000_0000_0000_0800, 2'd2, 2'd1, 16'h0, 64'hFFFC_0000_0000_0000, 1'b0,
             "R1 R4 ext->dbl");
        send(16'h7FFF, 64'h8000_0000_0000_0000, 2'd2, 2'd0, 16'h0, 64'h7FC0_0000, 1'b0,
             "R5 ext integer bit only not signaling");
        send(16'h7FFF, 64'h8000_0000_0000_0001, 2'd2, 2'd2, 16'h7FFF, 64'h8000_0000_0000_0001, 1'b1,
             "R4 R5 ext signaling identity");
        send(16'h7FFF, 64'h0, 2'd2, 2'd2, 16'h7FFF, 64'hC000_0000_0000_0000, 1'b0,
             "R7 ext zero significand");
        send(16'h0, 64'h7FF0_0000_0000_0000, 2'd1, 2'd1, 16'h0, 64'hFFF8_0000_0000_0000, 1'b0,
             "R7 dbl zero fraction");
        send(16'h0, 64'hFFF0_0000_0000_0005, 2'd1, 2'd1, 16'h0, 64'hFFF0_0000_0000_0005, 1'b1,
             "R1 R5 dbl identity");
        send(16'h0, 64'h7FC0_0001, 2'd3, 2'd1, 16'h0, 64'hFFF8_0000_0000_0000, 1'b0,
             "R9 reserved src->dbl");
        send(16'h0, 64'h7FC0_0001, 2'd3, 2'd2, 16'h7FFF, 64'hC000_0000_0000_0000, 1'b0,
             "R9 reserved src->ext");
        send(16'h0, 64'h7F80_0001, 2'd0, 2'd3, 16'h0, 64'h0, 1'b1, "R9 reserved dst");

        // round trips single -> double -> single (R10)
        for (int i = 0; i < 16; i++) begin
            logic [22:0] f;
            logic        s;
            logic        sn;
            logic [31:0] w;
            logic [63:0] d;
            f  = 23'((i * 32'h0005_A3C1) + 1) | 23'h1;
            s  = i[0];
            sn = !f[22] && (f[21:0] != 22'h0);
            w  = {s, 8'hFF, f};
            d  = {s, 11'h7FF, f, 29'h0};
            send(16'h0, {32'h0, w}, 2'd0, 2'd1, 16'h0, d, sn, "R2 R10 round trip out");
            send(16'h0, d, 2'd1, 2'd0, 16'h0, {32'h0, w}, sn, "R10 round trip back");
        end

        // doubles confined to fraction bits 28:0 collapse when narrowed (R3)
        for (int i = 0; i < 8; i++) begin
            logic [28:0] lo29;
            lo29 = 29'((i + 1) * 32'h0123_4567) | 29'h1;
            send(16'h0, {i[0], 11'h7FF, 23'h0, lo29}, 2'd1, 2'd0, 16'h0, 64'hFFC0_0000, 1'b1,
                 "R3 R7 narrow collapse");
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule